// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block frees a two-wire serial bus that a slave has left hung after an interrupted transfer or a reset. A single trigger pulse starts a fixed pattern on the open-drain lines. It first makes a start condition. It then gives nine dummy clock pulses with the data line left free, makes a second start, and ends at once with a stop. The block drives only the two pull-low enables; the bus pull-ups make the high levels.

Every phase of the pattern lasts a fixed number of system clock cycles. Those numbers are parameters, with one set for a slow bus and one for a fast bus. A mode input, sampled when the trigger is taken, selects the set. At the end the block reads the data line. It gives a one-cycle completion pulse and a flag that stays set when the line is still held low. That flag means software can do nothing more and the bus needs a power cycle.

Top module: `bus_recovery_top`

## Requirements
- R1: During and after reset both line enables are off (0 = line released, 1 = pull low), and busy, done and fail are all 0.
- R2: A trigger accepted while idle first leaves both lines released for the start-setup count. It then pulls the data line low while the clock line stays released, for the start-hold count. This is the first start condition.
- R3: Exactly nine clock pulses follow. Each is the clock line pulled low for the low count, then released for the high count. The data enable stays off for all nine.
- R4: After the ninth pulse the clock line is pulled low for the low count with data released. Both lines are then released for the start-setup count, and data is pulled low for the start-hold count. This is the second start.
- R5: The stop follows. Both lines are pulled low for the low count, and the clock is released with data still low for the stop-setup count. Data is then released, and both lines stay free for the bus-free count.
- R6: done is high for exactly one cycle, the first cycle after the bus-free phase. busy is high from the cycle after the trigger through the bus-free phase, and low in the done cycle.
- R7: fail is updated in the done cycle. It is set to 1 when the synchronized data line is low at the end of the bus-free phase and cleared to 0 when the line is high, and it holds that value until the next completion.
- R8: fast_i is sampled when the trigger is accepted. 1 selects the fast counts and 0 the slow counts. A change of fast_i during a run has no effect on that run.
- R9: A trigger while busy is ignored: the running pattern continues unchanged and does not restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Start a recovery pattern (one-cycle pulse) |
| fast_i | input | 1 | Timing set select: 1 fast, 0 slow |
| sda_i | input | 1 | Level read back from the data line |
| scl_oe_o | output | 1 | Pull the clock line low when 1 |
| sda_oe_o | output | 1 | Pull the data line low when 1 |
| busy_o | output | 1 | Pattern in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Data line found stuck low at the end |

## Verification
Each drive segment is due to last exactly its phase count, measured from the first falling-edge sample at which busy is high. busy is high in the cycle after the trigger edge. The completion pulse and the fail flag are due in the cycle straight after the bus-free segment. The monitor samples the enables at each falling clock edge and measures segment lengths rather than absolute times. It closes a segment when the enable pair changes, or when done appears, and compares the segment with the next item the driver queued. Every edge and length is therefore checked against the cycle in which it is due, and any cycle gained or lost is reported.

// File: rtl/bus_recovery_pkg.sv
// Package: shared types for the bus recovery sequencer.
// Holds the phase and duration enumerations, the pair of line enables,
// and the pure functions that map a phase to its drive and its duration.
package bus_recovery_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_S1_SU,
        PH_S1_HD,
        PH_CK_LO,
        PH_CK_HI,
        PH_S2_LO,
        PH_S2_SU,
        PH_S2_HD,
        PH_P_LO,
        PH_P_SU,
        PH_P_BUF
    } phase_e;

    typedef enum logic [2:0] {
        DUR_LOW,
        DUR_HIGH,
        DUR_SU_STA,
        DUR_HD_STA,
        DUR_SU_STO,
        DUR_BUF
    } dur_e;

    typedef struct packed {
        logic scl_oe;
        logic sda_oe;
    } drive_t;

    // Enables that hold while a phase is active (1 = pull low)
    function automatic drive_t drive_of(phase_e p);
        drive_t d;
        case (p)
            PH_S1_HD: d = '{scl_oe: 1'b0, sda_oe: 1'b1};
            PH_CK_LO: d = '{scl_oe: 1'b1, sda_oe: 1'b0};
            PH_S2_LO: d = '{scl_oe: 1'b1, sda_oe: 1'b0};
            PH_S2_HD: d = '{scl_oe: 1'b0, sda_oe: 1'b1};
            PH_P_LO:  d = '{scl_oe: 1'b1, sda_oe: 1'b1};
            PH_P_SU:  d = '{scl_oe: 1'b0, sda_oe: 1'b1};
            default:  d = '{scl_oe: 1'b0, sda_oe: 1'b0};
        endcase
        return d;
    endfunction

    // Which timing count a phase lasts for
    function automatic dur_e dur_of(phase_e p);
        dur_e r;
        case (p)
            PH_S1_SU, PH_S2_SU: r = DUR_SU_STA;
            PH_S1_HD, PH_S2_HD: r = DUR_HD_STA;
            PH_CK_HI:           r = DUR_HIGH;
            PH_P_SU:            r = DUR_SU_STO;
            PH_P_BUF:           r = DUR_BUF;
            default:            r = DUR_LOW;
        endcase
        return r;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bus_recovery_sync.sv
// Module: bus_recovery_sync
// Brings the asynchronous line level into the clock domain through a
// chain of STAGES flops. Assumes STAGES >= 1; resets to RST_VAL (an idle
// bus reads high).
module bus_recovery_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single-stage capture
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d_i;
            end
        end else begin : g_many
            // Shift the level along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/bus_recovery_timer.sv
// Module: bus_recovery_timer
// Phase timer. On load_i it takes the count picked by dur_i and fast_i,
// minus one, then counts down to zero; expire_o is high while the count is
// zero, so a phase loaded with N lasts exactly N cycles. Assumes every
// count parameter is at least 1.
module bus_recovery_timer
    import bus_recovery_pkg::*;
#(
    parameter int SLOW_LOW    = 260,
    parameter int SLOW_HIGH   = 120,
    parameter int SLOW_SU_STA = 120,
    parameter int SLOW_HD_STA = 120,
    parameter int SLOW_SU_STO = 120,
    parameter int SLOW_BUF    = 260,
    parameter int FAST_LOW    = 80,
    parameter int FAST_HIGH   = 80,
    parameter int FAST_SU_STA = 50,
    parameter int FAST_HD_STA = 50,
    parameter int FAST_SU_STO = 50,
    parameter int FAST_BUF    = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  dur_e dur_i,
    input  logic fast_i,
    output logic expire_o
);
    localparam int SLOW_MAX = imax(imax(imax(SLOW_LOW, SLOW_HIGH), imax(SLOW_SU_STA, SLOW_HD_STA)),
                                   imax(SLOW_SU_STO, SLOW_BUF));
    localparam int FAST_MAX = imax(imax(imax(FAST_LOW, FAST_HIGH), imax(FAST_SU_STA, FAST_HD_STA)),
                                   imax(FAST_SU_STO, FAST_BUF));
    localparam int CNT_W    = $clog2(imax(SLOW_MAX, FAST_MAX) + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] sel;

    // Pick the reload count for the phase being entered
    always_comb begin
        case (dur_i)
            DUR_HIGH:   sel = fast_i ? CNT_W'(FAST_HIGH)   : CNT_W'(SLOW_HIGH);
            DUR_SU_STA: sel = fast_i ? CNT_W'(FAST_SU_STA) : CNT_W'(SLOW_SU_STA);
            DUR_HD_STA: sel = fast_i ? CNT_W'(FAST_HD_STA) : CNT_W'(SLOW_HD_STA);
            DUR_SU_STO: sel = fast_i ? CNT_W'(FAST_SU_STO) : CNT_W'(SLOW_SU_STO);
            DUR_BUF:    sel = fast_i ? CNT_W'(FAST_BUF)    : CNT_W'(SLOW_BUF);
            default:    sel = fast_i ? CNT_W'(FAST_LOW)    : CNT_W'(SLOW_LOW);
        endcase
    end

    // Reload on phase entry, otherwise count down and rest at zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load_i)     cnt <= sel - CNT_W'(1);
        else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
    end

    assign expire_o = (cnt == '0);

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R8
    cnt_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/bus_recovery_fsm.sv
// Module: bus_recovery_fsm
// Phase sequencer: start, NUM_CLKS dummy clocks, second start, stop, bus
// free, then the line check. The enables are registered from the next
// phase, so they change on the same edge as the phase and never glitch.
// Assumes the timer reloads on load_o and reports expire_i when the
// current phase has run its count.
module bus_recovery_fsm
    import bus_recovery_pkg::*;
#(
    parameter int NUM_CLKS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic fast_i,
    input  logic expire_i,
    input  logic sda_sync_i,
    output logic load_o,
    output dur_e dur_o,
    output logic fast_eff_o,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic busy_o,
    output logic done_o,
    output logic fail_o
);
    localparam int CK_W = $clog2(NUM_CLKS + 1);

    phase_e          state, state_n;
    logic [CK_W-1:0] ck_cnt;
    logic            fast_q;
    drive_t          drv_q;
    logic            done_q, fail_q;
    logic            last_clk;
    logic            accept;

    assign accept   = (state == PH_IDLE) && trig_i;
    assign last_clk = (ck_cnt == CK_W'(NUM_CLKS - 1));

    // Next-phase choice and timer reload request
    always_comb begin
        state_n = state;
        load_o  = 1'b0;
        case (state)
            PH_IDLE: begin
                if (trig_i) begin
                    state_n = PH_S1_SU;
                    load_o  = 1'b1;
                end
            end
            PH_P_BUF: begin
                if (expire_i) state_n = PH_IDLE;
            end
            default: begin
                if (expire_i) begin
                    load_o = 1'b1;
                    case (state)
                        PH_S1_SU: state_n = PH_S1_HD;
                        PH_S1_HD: state_n = PH_CK_LO;
                        PH_CK_LO: state_n = PH_CK_HI;
                        PH_CK_HI: state_n = last_clk ? PH_S2_LO : PH_CK_LO;
                        PH_S2_LO: state_n = PH_S2_SU;
                        PH_S2_SU: state_n = PH_S2_HD;
                        PH_S2_HD: state_n = PH_P_LO;
                        PH_P_LO:  state_n = PH_P_SU;
                        default:  state_n = PH_P_BUF;
                    endcase
                end
            end
        endcase
    end

    assign dur_o      = dur_of(state_n);
    assign fast_eff_o = (state == PH_IDLE) ? fast_i : fast_q;

    // Phase register and registered line enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            drv_q <= '0;
        end else begin
            state <= state_n;
            drv_q <= drive_of(state_n);
        end
    end

    // Mode latch and dummy clock count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
            ck_cnt <= '0;
        end else if (accept) begin
            fast_q <= fast_i;
            ck_cnt <= '0;
        end else if (state == PH_CK_HI && expire_i) begin
            ck_cnt <= ck_cnt + CK_W'(1);
        end
    end

    // Completion pulse and line check at the end of bus free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= (state == PH_P_BUF) && expire_i;
            if ((state == PH_P_BUF) && expire_i) fail_q <= ~sda_sync_i;
        end
    end

    assign scl_oe_o = drv_q.scl_oe;
    assign sda_oe_o = drv_q.sda_oe;
    assign busy_o   = (state != PH_IDLE);
    assign done_o   = done_q;
    assign fail_o   = fail_q;

    // R3
    ck_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ck_cnt <= CK_W'(NUM_CLKS));

    // R3
    clk_sda_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_CK_LO || state == PH_CK_HI) |-> !drv_q.sda_oe);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state == PH_IDLE));

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_IDLE && state != PH_S1_SU) |=> (state != PH_S1_SU));

    // R5
    stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(drv_q.sda_oe) && !drv_q.scl_oe) |-> (state == PH_P_BUF));

    // R2
    start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(drv_q.sda_oe) && !drv_q.scl_oe) |-> (state == PH_S1_HD || state == PH_S2_HD));
endmodule

// File: rtl/bus_recovery_top.sv
// Module: bus_recovery_top
// Bus recovery sequencer top: joins the line synchronizer, the phase timer
// and the phase sequencer. Assumes the two enables drive open-drain pads
// and that sda_i reads the resolved data line.
module bus_recovery_top #(
    parameter int NUM_CLKS    = 9,
    parameter int SYNC_STAGES = 2,
    parameter int SLOW_LOW    = 260,
    parameter int SLOW_HIGH   = 120,
    parameter int SLOW_SU_STA = 120,
    parameter int SLOW_HD_STA = 120,
    parameter int SLOW_SU_STO = 120,
    parameter int SLOW_BUF    = 260,
    parameter int FAST_LOW    = 80,
    parameter int FAST_HIGH   = 80,
    parameter int FAST_SU_STA = 50,
    parameter int FAST_HD_STA = 50,
    parameter int FAST_SU_STO = 50,
    parameter int FAST_BUF    = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic fast_i,
    input  logic sda_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic busy_o,
    output logic done_o,
    output logic fail_o
);
    import bus_recovery_pkg::*;

    logic sda_sync;
    logic load;
    dur_e dur;
    logic fast_eff;
    logic expire;

    bus_recovery_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sda_i),
        .q_o   (sda_sync)
    );

    bus_recovery_timer #(
        .SLOW_LOW    (SLOW_LOW),
        .SLOW_HIGH   (SLOW_HIGH),
        .SLOW_SU_STA (SLOW_SU_STA),
        .SLOW_HD_STA (SLOW_HD_STA),
        .SLOW_SU_STO (SLOW_SU_STO),
        .SLOW_BUF    (SLOW_BUF),
        .FAST_LOW    (FAST_LOW),
        .FAST_HIGH   (FAST_HIGH),
        .FAST_SU_STA (FAST_SU_STA),
        .FAST_HD_STA (FAST_HD_STA),
        .FAST_SU_STO (FAST_SU_STO),
        .FAST_BUF    (FAST_BUF)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .dur_i    (dur),
        .fast_i   (fast_eff),
        .expire_o (expire)
    );

    bus_recovery_fsm #(
        .NUM_CLKS (NUM_CLKS)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig_i),
        .fast_i     (fast_i),
        .expire_i   (expire),
        .sda_sync_i (sda_sync),
        .load_o     (load),
        .dur_o      (dur),
        .fast_eff_o (fast_eff),
        .scl_oe_o   (scl_oe_o),
        .sda_oe_o   (sda_oe_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .fail_o     (fail_o)
    );
endmodule

// File: tb/bus_recovery_top_tb_top.sv
// Scoreboard bench for bus_recovery_top: a driver queues the expected
// drive segments of each run; a falling-edge monitor measures the segments
// the design produces and compares them in order.
module bus_recovery_top_tb_top;

    localparam int PER_NS = 5;
    localparam int S_LOW = 1300 / PER_NS, S_HIGH = 600 / PER_NS, S_SUSTA = 600 / PER_NS;
    localparam int S_HDSTA = 600 / PER_NS, S_SUSTO = 600 / PER_NS, S_BUF = 1300 / PER_NS;
    localparam int F_LOW = 400 / PER_NS, F_HIGH = 400 / PER_NS, F_SUSTA = 250 / PER_NS;
    localparam int F_HDSTA = 250 / PER_NS, F_SUSTO = 250 / PER_NS, F_BUF = 500 / PER_NS;

    typedef struct {
        bit    scl;
        bit    sda;
        int    len;
        string req;
    } seg_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_i = 1'b0;
    logic fast_i = 1'b0;
    logic stuck_low = 1'b0;
    logic sda_i;
    logic scl_oe_o, sda_oe_o, busy_o, done_o, fail_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int done_seen = 0;
    bit exp_fail = 1'b0;
    seg_t exp_q[$];

    assign sda_i = ~(sda_oe_o | stuck_low);

    always #2.5 clk = ~clk;

    bus_recovery_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig_i),
        .fast_i   (fast_i),
        .sda_i    (sda_i),
        .scl_oe_o (scl_oe_o),
        .sda_oe_o (sda_oe_o),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .fail_o   (fail_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(1'b0, "WDOG", "watchdog expired", cycles, 150000);
            finish_run();
        end
    end

    task automatic push(input bit scl, input bit sda, input int len, input string req);
        seg_t s;
        s.scl = scl; s.sda = sda; s.len = len; s.req = req;
        exp_q.push_back(s);
    endtask

    // Driver side: queue the whole expected pattern for one run
    task automatic push_run(input bit fast);
        int lo, hi, su, hd, sto, buf_c;
        lo  = fast ? F_LOW   : S_LOW;
        hi  = fast ? F_HIGH  : S_HIGH;
        su  = fast ? F_SUSTA : S_SUSTA;
        hd  = fast ? F_HDSTA : S_HDSTA;
        sto = fast ? F_SUSTO : S_SUSTO;
        buf_c = fast ? F_BUF : S_BUF;
        push(0, 0, su, "R2");
        push(0, 1, hd, "R2");
        for (int i = 0; i < 9; i++) begin
            push(1, 0, lo, "R3");
            push(0, 0, hi, "R3");
        end
        push(1, 0, lo, "R4");
        push(0, 0, su, "R4");
        push(0, 1, hd, "R4");
        push(1, 1, lo, "R5");
        push(0, 1, sto, "R5");
        push(0, 0, buf_c, "R5");
    endtask

    // Monitor side: measure segments and compare with the queue
    bit tracking = 1'b0;
    bit cur_scl, cur_sda;
    int cur_len;

    task automatic close_seg();
        seg_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R9", "unexpected extra segment", cur_len, 0);
        end else begin
            e = exp_q.pop_front();
            chk(cur_scl == e.scl && cur_sda == e.sda, e.req, "segment enables",
                {cur_scl, cur_sda}, {e.scl, e.sda});
            chk(cur_len == e.len, e.req, "segment length", cur_len, e.len);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (!tracking) begin
                if (busy_o) begin
                    tracking = 1'b1;
                    cur_scl  = scl_oe_o;
                    cur_sda  = sda_oe_o;
                    cur_len  = 1;
                end
            end else if (done_o) begin
                close_seg();
                chk(exp_q.size() == 0, "R9", "segments left at done", exp_q.size(), 0);
                exp_q.delete();
                chk(busy_o == 1'b0, "R6", "busy in done cycle", busy_o, 0);
                chk(fail_o == exp_fail, "R7", "fail at done", fail_o, exp_fail);
                tracking = 1'b0;
                done_seen++;
            end else if ({scl_oe_o, sda_oe_o} != {cur_scl, cur_sda}) begin
                close_seg();
                cur_scl = scl_oe_o;
                cur_sda = sda_oe_o;
                cur_len = 1;
            end else begin
                cur_len++;
                if (!busy_o) chk(1'b0, "R6", "busy dropped before done", busy_o, 1);
            end
        end
    end

    // One run: trigger, optional mode flip, retrigger and line release
    task automatic run_seq(input bit fast, input bit stuck, input bit efail,
                           input int flip_at, input int retrig_at, input int release_at);
        int prev;
        int k;
        prev = done_seen;
        push_run(fast);
        exp_fail = efail;
        @(negedge clk);
        fast_i = fast;
        stuck_low = stuck;
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        k = 1;
        while (done_seen == prev) begin
            @(negedge clk);
            k++;
            if (k == flip_at)    fast_i = ~fast_i;
            trig_i = (k == retrig_at);
            if (k == release_at) stuck_low = 1'b0;
        end
        trig_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(fail_o == efail, "R7", "fail held after done", fail_o, efail);
        chk(done_o == 1'b0, "R6", "done after pulse", done_o, 0);
        chk({scl_oe_o, sda_oe_o} == 2'b00, "R6", "enables idle after run", {scl_oe_o, sda_oe_o}, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(scl_oe_o == 1'b0, "R1", "scl enable in reset", scl_oe_o, 0);
        chk(sda_oe_o == 1'b0, "R1", "sda enable in reset", sda_oe_o, 0);
        chk(busy_o == 1'b0,   "R1", "busy in reset", busy_o, 0);
        chk(done_o == 1'b0,   "R1", "done in reset", done_o, 0);
        chk(fail_o == 1'b0,   "R1", "fail in reset", fail_o, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);

        // R8: slow run, mode flipped mid-run has no effect
        run_seq(1'b0, 1'b0, 1'b0, 500, -1, -1);
        // R7: fast run with data held low throughout
        run_seq(1'b1, 1'b1, 1'b1, -1, -1, -1);
        // R9: fast run, retrigger while busy, slave releases mid-run
        run_seq(1'b1, 1'b1, 1'b0, -1, 300, 600);
        // R8: slow run again after a fast one
        run_seq(1'b0, 1'b0, 1'b0, -1, 1000, -1);

        chk(done_seen == 4, "R6", "completions seen", done_seen, 4);
        finish_run();
    end
endmodule